// File: doc/BRIEF.md
# Decoded Four-Port Register File

This block holds the general registers of a simple sequential processor and works out for itself which registers each instruction touches. It takes the 4-bit instruction code, the two register specifier nibbles and the condition flag from the execute stage. From these it derives two read addresses and two write addresses. Operand values are read combinationally. The execute result (port E) and the memory result (port M) are written on the rising clock edge.

There are fifteen 64-bit registers, numbered 0 to 14. The register number 0xF means "no register": a read of it returns zero and a write to it stores nothing. Register 4 is the stack pointer. Stack instructions read and write it implicitly, whatever the specifier nibbles hold. A conditional register move writes its destination only when the condition flag is set.

Instruction codes used throughout: 0 halt, 1 no-op, 2 register move (conditional), 3 immediate move, 4 register-to-memory store, 5 memory-to-register load, 6 ALU operation, 7 jump, 8 call, 9 return, 0xA push, 0xB pop. Codes 0xC to 0xF use no register.

Top module: `regfile_decode`

## Requirements
- R1: While reset is high, every register clears to zero at each rising edge. After reset, every register reads as zero until it is written.
- R2: The A read address is rA for codes 2, 4, 6 and 0xA. It is register 4 for codes 9 and 0xB. For every other code it is 0xF, so val_a is zero.
- R3: The B read address is rB for codes 3, 4, 5 and 6. It is register 4 for codes 8, 9, 0xA and 0xB. For every other code it is 0xF, so val_b is zero.
- R4: The E write address is rB for codes 3 and 6, and for code 2 when cnd is 1. It is register 4 for codes 8, 9, 0xA and 0xB. For every other code it is 0xF. val_e is stored at that address on the rising edge.
- R5: A code 2 instruction with cnd at 0 leaves register rB unchanged.
- R6: The M write address is rA for codes 5 and 0xB, and 0xF for every other code. val_m is stored at that address on the rising edge.
- R7: Specifier 0xF reads as zero and writes nothing. For example, code 6 with rB = 0xF changes no register.
- R8: When the E and M write addresses name the same register, that register takes val_m. An example is pop (code 0xB) with rA = 4.
- R9: Reads are combinational and writes take effect only at the rising edge. A read of the register being written in the same cycle shows its old value until that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all registers |
| icode | input | 4 | Instruction code |
| ra | input | 4 | First register specifier |
| rb | input | 4 | Second register specifier |
| cnd | input | 1 | Condition flag from the execute stage |
| val_e | input | 64 | Write data for port E |
| val_m | input | 64 | Write data for port M |
| val_a | output | 64 | Read data from port A |
| val_b | output | 64 | Read data from port B |

## Verification
Every register is first loaded with a distinct pattern. This makes a read from the wrong address show up as a wrong value, not a coincidental zero. Directed cases cover the following:
- a not-taken and a taken conditional move, which separate the cnd gating from ordinary writes;
- a pop with rA = 4, which shows which write port wins a collision;
- a read of a register in the same cycle it is written, which shows whether writes are visible before the edge;
- specifiers of 0xF on reads and on writes;
- a reset in the middle of the run, after the registers hold data.

Several hundred random instructions then cover all sixteen codes and every specifier value, with random cnd and write data. These catch decode errors for codes the directed cases do not reach.

// File: rtl/regfile_decode.sv
module regfile_decode #(
  parameter int DW = 64,
  parameter int AW = 4,
  parameter logic [AW-1:0] SP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    icode,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  input  logic          cnd,
  input  logic [DW-1:0] val_e,
  input  logic [DW-1:0] val_m,
  output logic [DW-1:0] val_a,
  output logic [DW-1:0] val_b
);
  localparam int NREG = (1 << AW) - 1;
  localparam logic [AW-1:0] NONE = '1;

  localparam logic [3:0] C_MOVR  = 4'h2;
  localparam logic [3:0] C_MOVI  = 4'h3;
  localparam logic [3:0] C_STORE = 4'h4;
  localparam logic [3:0] C_LOAD  = 4'h5;
  localparam logic [3:0] C_ALU   = 4'h6;
  localparam logic [3:0] C_CALL  = 4'h8;
  localparam logic [3:0] C_RET   = 4'h9;
  localparam logic [3:0] C_PUSH  = 4'hA;
  localparam logic [3:0] C_POP   = 4'hB;

  logic [DW-1:0] regs [NREG];
  logic [AW-1:0] src_a, src_b, dst_e, dst_m;

  always_comb begin
    case (icode)
      C_MOVR, C_STORE, C_ALU, C_PUSH: src_a = ra;
      C_RET, C_POP:                   src_a = SP;
      default:                        src_a = NONE;
    endcase
    case (icode)
      C_MOVI, C_STORE, C_LOAD, C_ALU:   src_b = rb;
      C_CALL, C_RET, C_PUSH, C_POP:     src_b = SP;
      default:                          src_b = NONE;
    endcase
    case (icode)
      C_MOVR:                           dst_e = cnd ? rb : NONE;
      C_MOVI, C_ALU:                    dst_e = rb;
      C_CALL, C_RET, C_PUSH, C_POP:     dst_e = SP;
      default:                          dst_e = NONE;
    endcase
    case (icode)
      C_LOAD, C_POP: dst_m = ra;
      default:       dst_m = NONE;
    endcase
  end

  assign val_a = (src_a == NONE) ? '0 : regs[src_a];
  assign val_b = (src_b == NONE) ? '0 : regs[src_b];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)                    regs[i] <= '0;
      else if (dst_m == AW'(i))   regs[i] <= val_m;
      else if (dst_e == AW'(i))   regs[i] <= val_e;
    end
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (val_a == '0 && val_b == '0));

  // R2 R3: codes with no register operand read zero
  a_r2_halt_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (icode == 4'h0 || icode == 4'h1 || icode == 4'h7) |-> (val_a == '0 && val_b == '0));

  a_r4_port_e_write: assert property (@(posedge clk) disable iff (rst)
    (dst_e != NONE && dst_e != dst_m) |=> regs[$past(dst_e)] == $past(val_e));

  a_r5_cmov_suppressed: assert property (@(posedge clk) disable iff (rst)
    (icode == C_MOVR && !cnd && rb != NONE) |=> regs[$past(rb)] == $past(regs[rb]));

  a_r6_port_m_write: assert property (@(posedge clk) disable iff (rst)
    (dst_m != NONE) |=> regs[$past(dst_m)] == $past(val_m));

  a_r8_m_priority: assert property (@(posedge clk) disable iff (rst)
    (icode == C_POP && ra == SP) |=> regs[SP] == $past(val_m));
endmodule

// File: tb/tb_regfile_decode.sv
module tb_regfile_decode;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] NONE = 4'hF;
  localparam logic [3:0] SPR  = 4'h4;

  logic        clk = 0;
  logic        rst = 1;
  logic [3:0]  icode = 0, ra = 0, rb = 0;
  logic        cnd = 0;
  logic [63:0] val_e = 0, val_m = 0;
  logic [63:0] val_a, val_b;

  logic [63:0] model [15];
  int checks = 0;
  int errors = 0;

  regfile_decode dut (.clk(clk), .rst(rst), .icode(icode), .ra(ra), .rb(rb), .cnd(cnd),
                      .val_e(val_e), .val_m(val_m), .val_a(val_a), .val_b(val_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] e_src_a(logic [3:0] c, logic [3:0] a);
    if (c == 2 || c == 4 || c == 6 || c == 4'hA) return a;
    if (c == 9 || c == 4'hB) return SPR;
    return NONE;
  endfunction
  function automatic logic [3:0] e_src_b(logic [3:0] c, logic [3:0] b);
    if (c == 3 || c == 4 || c == 5 || c == 6) return b;
    if (c == 8 || c == 9 || c == 4'hA || c == 4'hB) return SPR;
    return NONE;
  endfunction
  function automatic logic [3:0] e_dst_e(logic [3:0] c, logic [3:0] b, logic f);
    if (c == 2) return f ? b : NONE;
    if (c == 3 || c == 6) return b;
    if (c == 8 || c == 9 || c == 4'hA || c == 4'hB) return SPR;
    return NONE;
  endfunction
  function automatic logic [3:0] e_dst_m(logic [3:0] c, logic [3:0] a);
    return (c == 5 || c == 4'hB) ? a : NONE;
  endfunction
  function automatic logic [63:0] rd(logic [3:0] r);
    return (r == NONE) ? 64'd0 : model[r];
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(logic [3:0] c, logic [3:0] a, logic [3:0] b, logic f,
                      logic [63:0] ve, logic [63:0] vm, string ta, string tb);
    logic [3:0] de, dm;
    @(negedge clk);
    icode = c; ra = a; rb = b; cnd = f; val_e = ve; val_m = vm;
    #1;
    check(ta, val_a, rd(e_src_a(c, a)));
    check(tb, val_b, rd(e_src_b(c, b)));
    de = e_dst_e(c, b, f);
    dm = e_dst_m(c, a);
    if (de != NONE && de != dm) model[de] = ve;
    if (dm != NONE) model[dm] = vm;
  endtask

  task automatic probe(logic [3:0] a, logic [3:0] b, string tag);
    step(4'h4, a, b, 0, 64'd0, 64'd0, tag, tag);
  endtask

  task automatic fill(logic [63:0] base);
    for (int i = 0; i < 15; i++)
      step(4'h3, 4'hF, 4'(i), 0, base + 64'(i) * 64'h1111, 64'd0, "R3", "R4_fill");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; icode = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < 15; i++) model[i] = 64'd0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 15; i++) model[i] = 64'd0;
    do_reset();
    probe(4'h0, 4'h1, "R1_initial");
    fill(64'hA000_0000_0000_0000);
    do_reset();
    for (int i = 0; i < 15; i += 2) probe(4'(i), 4'(i + 1), "R1_after_reset");
    fill(64'h5000_0000_0000_1000);

    step(4'h2, 4'h1, 4'h2, 0, 64'hDEAD, 64'd0, "R2", "R3");
    probe(4'h2, 4'hF, "R5_cmov_not_taken");
    step(4'h2, 4'h1, 4'h2, 1, 64'hBEEF, 64'd0, "R2", "R3");
    probe(4'h2, 4'h2, "R4_cmov_taken");

    step(4'hB, SPR, 4'h7, 0, 64'h1234, 64'h5678, "R2_pop_sp", "R3_pop_sp");
    probe(SPR, SPR, "R8_m_priority");

    step(4'hB, 4'h9, 4'hF, 0, 64'h0F0F, 64'hAAAA, "R2", "R3");
    probe(SPR, 4'h9, "R6_pop_dest");
    step(4'h5, 4'h3, 4'h6, 0, 64'h1, 64'h3333, "R2", "R3");
    probe(4'h3, 4'h6, "R6_load");

    step(4'h6, 4'h5, 4'h5, 0, 64'h9999, 64'd0, "R9_old_value_a", "R9_old_value_b");
    probe(4'h5, 4'h5, "R9_new_value");

    step(4'h6, 4'hF, 4'hF, 0, 64'h7777, 64'd0, "R7_read_none", "R7_read_none");
    for (int i = 0; i < 15; i += 2) probe(4'(i), 4'(i + 1), "R7_no_write");

    step(4'hA, 4'h8, 4'h0, 0, 64'h4444, 64'd0, "R2_push", "R3_push");
    step(4'h8, 4'h0, 4'h0, 0, 64'h4440, 64'd0, "R2_call", "R3_call");
    step(4'h9, 4'h0, 4'h0, 0, 64'h4448, 64'd0, "R2_ret", "R3_ret");
    step(4'h7, 4'h1, 4'h2, 1, 64'h1, 64'h2, "R2_jump", "R3_jump");
    probe(SPR, 4'h8, "R4_stack");

    for (int n = 0; n < 400; n++) begin
      logic [3:0] c, a, b;
      c = 4'($urandom);
      a = 4'($urandom);
      b = 4'($urandom);
      step(c, a, b, 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
           "R2_random", "R3_random");
    end
    for (int i = 0; i < 15; i += 2) probe(4'(i), 4'(i + 1), "R4_R6_final");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule